// File: doc/BRIEF.md
# Four-Word Burst Quad-Data-Rate SRAM Model

This block is a synthesizable behavioural model of a quad-data-rate static memory in which every access moves four words. Write data and read data travel on separate ports. One address bus is shared by both ports. Each port has an active-low port select, and every write beat has active-low byte write selects. Both edges of the memory clock pair are folded onto a single clock. Each port therefore carries two words per cycle: a "rise" lane and a "fall" lane.

A write command presents a burst address. The four data words follow on the next two cycles. A read command presents a burst address, and the four words come back on the read lanes after one idle cycle. Because a command takes one address slot and its data takes two cycles, each port accepts at most one command every two cycles. A full-rate stream therefore alternates read and write commands on the address bus. The model is meant to sit under a controller in a testbench or a prototyping build in place of a board-level part. Its error flag reports protocol violations to the bench.

Top module: `qdr4_sram`

## Requirements
- R1: While reset is low and in the cycle after its release, `qRise` and `qFall` are zero and `protoErr` is low.
- R2: A write is accepted at a sampling edge n when `wpsN` is low and no write was accepted at edge n-1. The burst base is `addr` with its two low bits ignored. Words 0 and 1 are taken from `dRise`/`dFall` at edge n+1, and words 2 and 3 from `dRise`/`dFall` at edge n+2. They are stored at base+0 through base+3.
- R3: A read is accepted at edge n when `rpsN` is low and no read was accepted at edge n-1. Words base+0 and base+1 appear on `qRise`/`qFall` from edge n+2 to edge n+3. Words base+2 and base+3 appear from edge n+3 to edge n+4.
- R4: In any cycle that is not delivering read words, `qRise` and `qFall` are zero.
- R5: Bit i of `bwsRiseN`/`bwsFallN` covers data bits [i*BW +: BW] of the word in the same lane. It is sampled on that word's data edge. Low writes the byte. High leaves the stored byte unchanged.
- R6: A read accepted at edge n and a write accepted at edge n+1 to the same burst overlap at the memory. In that case the read returns the newly written data, merged by byte selects with the old contents.
- R7: A low `rpsN` at the edge after an accepted read is ignored: no read words result. `protoErr` is high for the following cycle.
- R8: A low `wpsN` at the edge after an accepted write is ignored: memory is unchanged. `protoErr` is high for the following cycle.
- R9: When `rpsN` and `wpsN` are both low at one edge and both ports are free, the read is accepted, the write is ignored, and `protoErr` is high for the following cycle.
- R10: Read and write commands alternating every cycle are all accepted with `protoErr` low. Each read returns the memory contents as defined by R2, R3, R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; both data edges of a cycle are modelled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset of control state and read lanes |
| rpsN | input | 1 | Active-low read port select |
| wpsN | input | 1 | Active-low write port select |
| addr | input | AW | Shared word address; low two bits ignored |
| dRise | input | NB*BW | Write data, even word of the beat pair |
| dFall | input | NB*BW | Write data, odd word of the beat pair |
| bwsRiseN | input | NB | Active-low byte write selects for `dRise` |
| bwsFallN | input | NB | Active-low byte write selects for `dFall` |
| qRise | output | NB*BW | Read data, even word of the beat pair |
| qFall | output | NB*BW | Read data, odd word of the beat pair |
| protoErr | output | 1 | High for one cycle after an edge at which a port select was ignored |

## Verification
A stuck or skipped busy bit in the command pipeline shows up in two ways within one cycle. `protoErr` appears or disappears against the expected pattern, and a read burst is shifted by a cycle or split across the wrong lanes. A wrong burst-half select or a wrong base address stays hidden until a later read of the affected locations. For that reason the bench preloads the whole memory and reads it all back. It also reads back after every write-side corner case, so that a corrupt store surfaces within a few cycles. Forwarding faults appear only when a read and a write to the same burst overlap one edge apart. The bench drives that case directly, with random byte selects.

// File: rtl/qdr4_pkg.sv
`timescale 1ns/1ps
package qdr4_pkg;
  // Strobes from the command pipeline to the storage datapath, valid for the coming edge.
  typedef struct packed {
    logic wrGo;  // a write beat pair lands at this edge
    logic wrHi;  // 0: words 0/1, 1: words 2/3
    logic rdGo;  // a read beat pair is loaded at this edge
    logic rdHi;  // 0: words 0/1, 1: words 2/3
  } strobe_t;
endpackage

// File: rtl/qdr4_ctrl.sv
`timescale 1ns/1ps
module qdr4_ctrl #(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rpsN,
  input  logic              wpsN,
  input  logic [AW-1:0]     addr,
  output qdr4_pkg::strobe_t strobe,
  output logic [AW-3:0]     wrBurst,
  output logic [AW-3:0]     rdBurst,
  output logic              protoErr
);
  localparam int BI = AW - 2;

  logic          rdV1, rdV2, rdV3;
  logic [BI-1:0] rdA1, rdA2, rdA3;
  logic          wrV1, wrV2;
  logic [BI-1:0] wrA1, wrA2;
  logic          rdTake, wrTake, dropHit;
  logic          unusedAddrLow;

  assign unusedAddrLow = ^addr[1:0];

  // A port is busy in the cycle right after it accepted a command.
  always_comb begin
    rdTake  = !rpsN && !rdV1;
    wrTake  = !wpsN && !wrV1 && !rdTake;
    dropHit = (!rpsN && rdV1) || (!wpsN && !wrTake);
  end

  always_comb begin
    strobe.wrGo = wrV1 | wrV2;
    strobe.wrHi = wrV2;
    strobe.rdGo = rdV2 | rdV3;
    strobe.rdHi = rdV3;
    wrBurst     = wrV2 ? wrA2 : wrA1;
    rdBurst     = rdV3 ? rdA3 : rdA2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdV1 <= 1'b0; rdV2 <= 1'b0; rdV3 <= 1'b0;
      rdA1 <= '0;   rdA2 <= '0;   rdA3 <= '0;
      wrV1 <= 1'b0; wrV2 <= 1'b0;
      wrA1 <= '0;   wrA2 <= '0;
      protoErr <= 1'b0;
    end else begin
      rdV1 <= rdTake;       rdA1 <= addr[AW-1:2];
      rdV2 <= rdV1;         rdA2 <= rdA1;
      rdV3 <= rdV2;         rdA3 <= rdA2;
      wrV1 <= wrTake;       wrA1 <= addr[AW-1:2];
      wrV2 <= wrV1;         wrA2 <= wrA1;
      protoErr <= dropHit;
    end
  end

  // R7
  rd_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdV2 && rdV3));

  // R8
  wr_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrV1 && wrV2));

  // R9
  both_sel_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rpsN && !wpsN) |=> protoErr);
endmodule

// File: rtl/qdr4_datapath.sv
`timescale 1ns/1ps
module qdr4_datapath #(
  parameter int AW = 8,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  qdr4_pkg::strobe_t    strobe,
  input  logic [AW-3:0]        wrBurst,
  input  logic [AW-3:0]        rdBurst,
  input  logic [NB*BW-1:0]     dRise,
  input  logic [NB*BW-1:0]     dFall,
  input  logic [NB-1:0]        bwsRiseN,
  input  logic [NB-1:0]        bwsFallN,
  output logic [NB*BW-1:0]     qRise,
  output logic [NB*BW-1:0]     qFall
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wIdx   [2];
  logic [AW-1:0] rIdx   [2];
  logic [DW-1:0] newWord[2];
  logic [DW-1:0] rdWord [2];

  function automatic logic [DW-1:0] mergeBytes(input logic [DW-1:0] oldW,
                                               input logic [DW-1:0] newW,
                                               input logic [NB-1:0] keepN);
    logic [DW-1:0] res;
    for (int b = 0; b < NB; b++)
      res[b*BW +: BW] = keepN[b] ? oldW[b*BW +: BW] : newW[b*BW +: BW];
    return res;
  endfunction

  // Lane 0 is the rise word, lane 1 the fall word of the beat pair.
  always_comb begin
    for (int ln = 0; ln < 2; ln++) begin
      wIdx[ln]    = {wrBurst, strobe.wrHi, 1'(ln)};
      rIdx[ln]    = {rdBurst, strobe.rdHi, 1'(ln)};
      newWord[ln] = mergeBytes(mem[wIdx[ln]], (ln == 0) ? dRise : dFall,
                               (ln == 0) ? bwsRiseN : bwsFallN);
      // Same-edge overlap: the read sees the word being written now.
      rdWord[ln]  = (strobe.wrGo && wIdx[ln] == rIdx[ln]) ? newWord[ln] : mem[rIdx[ln]];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrGo)
      for (int ln = 0; ln < 2; ln++) mem[wIdx[ln]] <= newWord[ln];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qRise <= '0;
      qFall <= '0;
    end else if (strobe.rdGo) begin
      qRise <= rdWord[0];
      qFall <= rdWord[1];
    end else begin
      qRise <= '0;
      qFall <= '0;
    end
  end

  // R4
  idle_q_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdGo |=> (qRise == '0 && qFall == '0));
endmodule

// File: rtl/qdr4_sram.sv
`timescale 1ns/1ps
module qdr4_sram #(
  parameter int AW = 8,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rpsN,
  input  logic               wpsN,
  input  logic [AW-1:0]      addr,
  input  logic [NB*BW-1:0]   dRise,
  input  logic [NB*BW-1:0]   dFall,
  input  logic [NB-1:0]      bwsRiseN,
  input  logic [NB-1:0]      bwsFallN,
  output logic [NB*BW-1:0]   qRise,
  output logic [NB*BW-1:0]   qFall,
  output logic               protoErr
);
  qdr4_pkg::strobe_t strobe;
  logic [AW-3:0]     wrBurst;
  logic [AW-3:0]     rdBurst;

  qdr4_ctrl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .rpsN(rpsN), .wpsN(wpsN), .addr(addr),
    .strobe(strobe), .wrBurst(wrBurst), .rdBurst(rdBurst), .protoErr(protoErr)
  );

  qdr4_datapath #(.AW(AW), .NB(NB), .BW(BW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrBurst(wrBurst), .rdBurst(rdBurst),
    .dRise(dRise), .dFall(dFall), .bwsRiseN(bwsRiseN), .bwsFallN(bwsFallN),
    .qRise(qRise), .qFall(qFall)
  );
endmodule

// File: tb/tb_qdr4_sram.sv
`timescale 1ns/1ps
module tb_qdr4_sram;
  localparam int AW = 8, NB = 2, BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, rpsN, wpsN;
  logic [AW-1:0] addr;
  logic [DW-1:0] dRise, dFall, qRise, qFall;
  logic [NB-1:0] bwsRiseN, bwsFallN;
  logic protoErr;

  qdr4_sram #(.AW(AW), .NB(NB), .BW(BW)) dut (
    .clk(clk), .rstN(rstN), .rpsN(rpsN), .wpsN(wpsN), .addr(addr),
    .dRise(dRise), .dFall(dFall), .bwsRiseN(bwsRiseN), .bwsFallN(bwsFallN),
    .qRise(qRise), .qFall(qFall), .protoErr(protoErr)
  );

  int checks = 0, errors = 0;
  string tag = "R1";
  bit randBws = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] expQR = '0, expQF = '0;
  logic expErr = 1'b0;
  bit mRs1 = 0, mRs2 = 0, mRs3 = 0, mWs1 = 0, mWs2 = 0;
  logic [AW-3:0] mRa1 = '0, mRa2 = '0, mRa3 = '0, mWa1 = '0, mWa2 = '0;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [NB-1:0] keepN);
    logic [DW-1:0] r = o;
    for (int b = 0; b < NB; b++) if (!keepN[b]) r[b*BW +: BW] = n[b*BW +: BW];
    return r;
  endfunction

  task automatic check();
    checks++;
    if (qRise !== expQR || qFall !== expQF || protoErr !== expErr) begin
      errors++;
      $display("FAIL %s q=%h/%h err=%b expected q=%h/%h err=%b",
               tag, qRise, qFall, protoErr, expQR, expQF, expErr);
    end
  endtask

  // Called just after a falling edge: check, drive, predict the next rising edge.
  task automatic cycle(input bit r, input bit w, input logic [AW-1:0] a);
    bit racc, wacc;
    check();
    rpsN = !r; wpsN = !w; addr = a;
    dRise = DW'($urandom); dFall = DW'($urandom);
    bwsRiseN = randBws ? NB'($urandom) : '0;
    bwsFallN = randBws ? NB'($urandom) : '0;
    if (mWs1) begin
      model[{mWa1, 2'd0}] = merge(model[{mWa1, 2'd0}], dRise, bwsRiseN);
      model[{mWa1, 2'd1}] = merge(model[{mWa1, 2'd1}], dFall, bwsFallN);
    end
    if (mWs2) begin
      model[{mWa2, 2'd2}] = merge(model[{mWa2, 2'd2}], dRise, bwsRiseN);
      model[{mWa2, 2'd3}] = merge(model[{mWa2, 2'd3}], dFall, bwsFallN);
    end
    if (mRs2)      begin expQR = model[{mRa2, 2'd0}]; expQF = model[{mRa2, 2'd1}]; end
    else if (mRs3) begin expQR = model[{mRa3, 2'd2}]; expQF = model[{mRa3, 2'd3}]; end
    else           begin expQR = '0; expQF = '0; end
    racc = r && !mRs1;
    wacc = w && !mWs1 && !racc;
    expErr = (r && mRs1) || (w && !wacc);
    mRs3 = mRs2; mRa3 = mRa2; mRs2 = mRs1; mRa2 = mRa1; mRs1 = racc; mRa1 = a[AW-1:2];
    mWs2 = mWs1; mWa2 = mWa1; mWs1 = wacc; mWa1 = a[AW-1:2];
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] pa [8];
    logic [AW-1:0] a, b;
    void'($urandom(32'h5eed));
    rstN = 0; rpsN = 1; wpsN = 1; addr = '0;
    dRise = '0; dFall = '0; bwsRiseN = '1; bwsFallN = '1;
    repeat (3) @(negedge clk);
    tag = "R1"; check();
    rstN = 1;
    idle(1);

    tag = "R2";  // preload, low address bits deliberately non-zero
    for (int k = 0; k < DEPTH/4; k++) begin
      cycle(0, 1, AW'(k*4 + (k % 4)));
      idle(1);
    end
    idle(2);

    tag = "R3";
    for (int k = 0; k < DEPTH/4; k++) begin
      cycle(1, 0, AW'(k*4));
      idle(1);
    end
    idle(3);

    tag = "R4"; idle(5);

    tag = "R5";
    randBws = 1;
    for (int k = 0; k < 8; k++) begin pa[k] = AW'($urandom); cycle(0, 1, pa[k]); idle(1); end
    randBws = 0;
    for (int k = 0; k < 8; k++) begin cycle(1, 0, pa[k]); idle(1); end
    idle(3);

    tag = "R6";
    randBws = 1;
    for (int k = 0; k < 6; k++) begin
      a = AW'($urandom);
      cycle(1, 0, a); cycle(0, 1, a); idle(3);
    end
    randBws = 0;

    tag = "R7";
    a = AW'($urandom); b = AW'($urandom);
    cycle(1, 0, a); cycle(1, 0, b); idle(4);

    tag = "R8";
    a = AW'($urandom); b = a ^ AW'(8'h40);
    cycle(0, 1, a); cycle(0, 1, b); idle(3);
    cycle(1, 0, b); idle(4);

    tag = "R9";
    a = AW'($urandom);
    cycle(1, 1, a); idle(3);
    cycle(1, 0, a); idle(4);

    tag = "R10";
    for (int k = 0; k < 300; k++) begin
      randBws = bit'($urandom);
      if (k % 2 == 0) cycle(1, 0, AW'($urandom));
      else            cycle(0, 1, AW'($urandom));
    end
    for (int k = 0; k < 300; k++) begin
      randBws = bit'($urandom);
      cycle(bit'($urandom), bit'($urandom), AW'($urandom));
    end
    randBws = 0;
    idle(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule